// File: doc/BRIEF.md
# Trinary Remote-Control Frame Encoder

This block turns eighteen code positions into a framed serial code on one output line, for a remote-control transmitter that drives an RF or infrared stage. Each position carries one of three states: one, zero or open. Every symbol is built from two sub-bits, and each sub-bit is a pulse whose width marks its value, so the three states produce three distinct waveforms. All timing comes from one clock through a divide-by-33 prescaler.

A frame, called a word, starts with a long low pilot. A short high sync pulse follows, and then the eighteen symbols, from position 0 to position 17. Words go out in bursts of three. A burst that has started always runs to its end, so a one-clock enable still yields three whole words. If the enable is still high when a burst ends, the next burst follows at once. A parameter selects the trigger. In one mode a dedicated enable input starts the transmission. In the other mode, any data position driven high starts it, and an indicator output shows when a transmission is in progress.

Positions that a configuration does not use still hold their slots in the word. An unused address slot is sent as open, and an unused data slot is sent as zero.

Top module: `trinary_frame_encoder`

## Requirements
- R1: After reset, and at all times while idle, `tx_out` and `tx_active` are low and no word is sent until an enable is seen.
- R2: A word is a pilot with `tx_out` low for 396 clocks (6 bits of 66 clocks), then a sync with `tx_out` high for 11 clocks, then 18 symbols of 66 clocks each, in the order position 0 to position 17. Position i is coded in `pos_code[2i+1:2i]`.
- R3: A symbol is two sub-bits of 33 clocks each. Every sub-bit starts high. A short sub-bit is high for 11 clocks and then low for 22. A long sub-bit is high for 22 clocks and then low for 11.
- R4: Code 2'b00 (zero) is sent as short,short. Code 2'b11 (one) is sent as long,long. Code 2'b01 (open) is sent as short,long. Code 2'b10 is sent the same way as open.
- R5: An enable seen high while idle starts a burst of exactly three back-to-back words (4785 clocks). A short enable pulse still gives all three words, and after them `tx_out` stays low.
- R6: If the enable is high on the clock that ends the third word, the pilot of a new burst starts on the next clock. Otherwise the block returns to idle.
- R7: The codes are captured on the clock that starts each word's pilot. A change made later in the word affects only the following word.
- R8: In transmit-enable mode (DATA_TRIGGER=0), `te` is the enable and `tx_active` stays low.
- R9: In data-trigger mode (DATA_TRIGGER=1), `te` is ignored. The enable is high when any used data position (index NUM_ADDR and up) has code 2'b11. Such a position is sent as one for 2'b11 and as zero for any other code.
- R10: A position whose USED_MASK bit is 0 is sent as open if it is an address position and as zero if it is a data position, whatever its input code. An unused data position never raises the enable.
- R11: In data-trigger mode, `tx_active` is high from the first pilot clock through the last clock of the final word, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bit timing is derived from it |
| rst_n | input | 1 | Synchronous reset, active low |
| te | input | 1 | Transmit enable, active high (transmit-enable mode only) |
| pos_code | input | 2*NUM_POS | Per-position three-state code, 2 bits per position |
| tx_out | output | 1 | Serial frame output |
| tx_active | output | 1 | Transmission-in-progress indicator (data-trigger mode) |

## Verification
The encoder is run with codes that are all zero, all one, all open, all 2'b10, zero and one in turn, and a mix of open address and one data positions. Every output clock of each word is compared with a model, and the long sub-bits of each word are counted. The all-open and all-2'b10 runs must match, which shows that the illegal code takes the open waveform, while the other patterns separate short, long and mixed symbols and show the position order. A one-clock enable, an enable held across a burst boundary, and a code change in the middle of a word separate burst completion, the repeat of bursts and the per-word capture of codes. A second instance in data-trigger mode, with address and data positions masked out, separates a real data trigger from open data codes, from unused data positions and from `te`.

// File: rtl/tfe_pkg.sv
// Shared types and code values for the trinary frame encoder.
// Assumes the 2-bit position codes: 00 zero, 11 one, 01 open, 10 handled as open.
package tfe_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PILOT = 2'd1,
        PH_SYNC  = 2'd2,
        PH_BITS  = 2'd3
    } phase_t;

    localparam logic [1:0] SYM_ZERO = 2'b00;
    localparam logic [1:0] SYM_OPEN = 2'b01;
    localparam logic [1:0] SYM_ONE  = 2'b11;

    // Value of one sub-bit (half 0 or 1) of a symbol; open is 0 then 1.
    function automatic logic sub_value(input logic [1:0] code, input logic half);
        case (code)
            SYM_ZERO: return 1'b0;
            SYM_ONE:  return 1'b1;
            default:  return half;
        endcase
    endfunction

endpackage

// File: rtl/tfe_prescaler.sv
// Divide-by-DIV sub-bit timer. Counts 0..DIV-1 and flags the last count.
// Assumes: clear holds it at zero while idle; restart aligns it at the end of the sync.
module tfe_prescaler #(
    parameter int DIV = 33,
    parameter int CW  = $clog2(DIV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          restart,
    output logic [CW-1:0] cnt,
    output logic          wrap
);

    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    assign wrap = (cnt == LAST);

    // Advance the sub-bit counter, folding back to zero at the end of a sub-bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (clear || restart || wrap) cnt <= '0;
        else                             cnt <= cnt + 1'b1;
    end

    AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);  // R3
    AST_PRESCALE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));  // R1

endmodule

// File: rtl/tfe_code_map.sv
// Maps raw position codes to the codes that are sent, and forms the enable.
// Assumes positions below NUM_ADDR are address slots and the rest are data slots.
module tfe_code_map
    import tfe_pkg::*;
#(
    parameter int                  NUM_POS      = 18,
    parameter int                  NUM_ADDR     = 12,
    parameter int                  DATA_TRIGGER = 0,
    parameter logic [NUM_POS-1:0]  USED_MASK    = '1
) (
    input  logic [2*NUM_POS-1:0] raw,
    input  logic                 te,
    output logic [2*NUM_POS-1:0] eff,
    output logic                 enable
);

    logic [NUM_POS-1:0] hit;

    for (genvar i = 0; i < NUM_POS; i++) begin : g_pos
        // A used data position that is driven high may raise the enable.
        assign hit[i] = (DATA_TRIGGER != 0) && (i >= NUM_ADDR) && USED_MASK[i]
                        && (raw[2*i +: 2] == SYM_ONE);
        if (USED_MASK[i] == 1'b0) begin : g_unused
            assign eff[2*i +: 2] = (i < NUM_ADDR) ? SYM_OPEN : SYM_ZERO;
        end else if ((DATA_TRIGGER != 0) && (i >= NUM_ADDR)) begin : g_data
            assign eff[2*i +: 2] = (raw[2*i +: 2] == SYM_ONE) ? SYM_ONE : SYM_ZERO;
        end else begin : g_pass
            assign eff[2*i +: 2] = raw[2*i +: 2];
        end
    end

    assign enable = (DATA_TRIGGER != 0) ? (|hit) : te;

endmodule

// File: rtl/tfe_symbol_gen.sv
// Pulse-width level of the current sub-bit from its code, half and prescaler count.
// Assumes cnt runs 0..SUB_CLKS-1 within the sub-bit.
module tfe_symbol_gen
    import tfe_pkg::*;
#(
    parameter int SUB_CLKS = 33,
    parameter int CW       = $clog2(SUB_CLKS)
) (
    input  logic [1:0]    code,
    input  logic          half,
    input  logic [CW-1:0] cnt,
    output logic          level
);

    localparam logic [CW-1:0] SHORT_HI = CW'(SUB_CLKS / 3);
    localparam logic [CW-1:0] LONG_HI  = CW'((2 * SUB_CLKS) / 3);

    logic sv;

    // Select the high time of the sub-bit and compare it with the count.
    always_comb begin
        sv    = sub_value(code, half);
        level = (cnt < (sv ? LONG_HI : SHORT_HI));
    end

endmodule

// File: rtl/tfe_sequencer.sv
// Word and burst sequencer: pilot, sync and symbol slots, three-word bursts,
// per-word code capture. Assumes pre_cnt/pre_wrap come from the prescaler it clears.
module tfe_sequencer
    import tfe_pkg::*;
#(
    parameter int NUM_POS    = 18,
    parameter int SUB_CLKS   = 33,
    parameter int PILOT_BITS = 6,
    parameter int WORDS      = 3,
    parameter int CW         = $clog2(SUB_CLKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [2*NUM_POS-1:0] codes,
    input  logic [CW-1:0]        pre_cnt,
    input  logic                 pre_wrap,
    output phase_t               phase,
    output logic [1:0]           cur_code,
    output logic                 half,
    output logic                 pre_clear,
    output logic                 pre_restart
);

    localparam int BIT_SLOTS   = 2 * NUM_POS;
    localparam int PILOT_SLOTS = 2 * PILOT_BITS;
    localparam int MAX_SLOTS   = (BIT_SLOTS > PILOT_SLOTS) ? BIT_SLOTS : PILOT_SLOTS;
    localparam int SW          = (MAX_SLOTS > 2) ? $clog2(MAX_SLOTS) : 2;
    localparam int WW          = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [SW-1:0] BIT_LAST   = SW'(BIT_SLOTS - 1);
    localparam logic [SW-1:0] PILOT_LAST = SW'(PILOT_SLOTS - 1);
    localparam logic [WW-1:0] WORD_LAST  = WW'(WORDS - 1);
    localparam logic [CW-1:0] SYNC_LAST  = CW'(SUB_CLKS / 3 - 1);

    logic [SW-1:0]        slot;
    logic [WW-1:0]        word_idx;
    logic [2*NUM_POS-1:0] snap;
    logic                 word_end;
    logic                 burst_end;

    assign word_end    = (phase == PH_BITS) && pre_wrap && (slot == BIT_LAST);
    assign burst_end   = word_end && (word_idx == WORD_LAST);
    assign pre_clear   = (phase == PH_IDLE);
    assign pre_restart = (phase == PH_SYNC) && (pre_cnt == SYNC_LAST);
    assign half        = slot[0];
    assign cur_code    = snap[{slot[SW-1:1], 1'b0} +: 2];

    // Step through pilot, sync and symbol slots; capture codes at each word start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            slot     <= '0;
            word_idx <= '0;
            snap     <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (enable) begin
                        phase    <= PH_PILOT;
                        slot     <= '0;
                        word_idx <= '0;
                        snap     <= codes;
                    end
                end
                PH_PILOT: begin
                    if (pre_wrap) begin
                        if (slot == PILOT_LAST) begin
                            phase <= PH_SYNC;
                            slot  <= '0;
                        end else begin
                            slot <= slot + 1'b1;
                        end
                    end
                end
                PH_SYNC: begin
                    if (pre_restart) phase <= PH_BITS;
                end
                PH_BITS: begin
                    if (pre_wrap) begin
                        if (slot == BIT_LAST) begin
                            slot <= '0;
                            if (word_idx == WORD_LAST) begin
                                word_idx <= '0;
                                if (enable) begin
                                    phase <= PH_PILOT;
                                    snap  <= codes;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end else begin
                                word_idx <= word_idx + 1'b1;
                                phase    <= PH_PILOT;
                                snap     <= codes;
                            end
                        end else begin
                            slot <= slot + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_WORD_CHAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && !burst_end) |=> (phase == PH_PILOT));  // R5
    AST_NO_EARLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase != PH_IDLE) && !burst_end) |=> (phase != PH_IDLE));  // R5
    AST_BURST_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_end && enable) |=> ((phase == PH_PILOT) && (word_idx == '0)));  // R6
    AST_CODES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase != PH_IDLE) && !word_end) |=> $stable(snap));  // R7

endmodule

// File: rtl/trinary_frame_encoder.sv
// Top of the trinary remote-control frame encoder. Serialises NUM_POS three-state
// positions as pilot, sync and pulse-width symbols in bursts of WORDS words.
// Assumes a single clock; DATA_TRIGGER selects te or data-position triggering.
module trinary_frame_encoder
    import tfe_pkg::*;
#(
    parameter int                 NUM_POS      = 18,
    parameter int                 NUM_ADDR     = 12,
    parameter int                 SUB_CLKS     = 33,
    parameter int                 PILOT_BITS   = 6,
    parameter int                 WORDS        = 3,
    parameter int                 DATA_TRIGGER = 0,
    parameter logic [NUM_POS-1:0] USED_MASK    = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 te,
    input  logic [2*NUM_POS-1:0] pos_code,
    output logic                 tx_out,
    output logic                 tx_active
);

    localparam int CW = $clog2(SUB_CLKS);
    localparam logic [CW-1:0] CNT_LAST = CW'(SUB_CLKS - 1);

    logic [2*NUM_POS-1:0] eff_codes;
    logic                 enable;
    logic [CW-1:0]        pre_cnt;
    logic                 pre_wrap;
    logic                 pre_clear;
    logic                 pre_restart;
    phase_t               phase;
    logic [1:0]           cur_code;
    logic                 half;
    logic                 sym_level;

    tfe_code_map #(
        .NUM_POS(NUM_POS), .NUM_ADDR(NUM_ADDR),
        .DATA_TRIGGER(DATA_TRIGGER), .USED_MASK(USED_MASK)
    ) u_map (
        .raw(pos_code), .te(te), .eff(eff_codes), .enable(enable)
    );

    tfe_prescaler #(.DIV(SUB_CLKS), .CW(CW)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(pre_clear), .restart(pre_restart),
        .cnt(pre_cnt), .wrap(pre_wrap)
    );

    tfe_sequencer #(
        .NUM_POS(NUM_POS), .SUB_CLKS(SUB_CLKS), .PILOT_BITS(PILOT_BITS),
        .WORDS(WORDS), .CW(CW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .codes(eff_codes),
        .pre_cnt(pre_cnt), .pre_wrap(pre_wrap), .phase(phase),
        .cur_code(cur_code), .half(half),
        .pre_clear(pre_clear), .pre_restart(pre_restart)
    );

    tfe_symbol_gen #(.SUB_CLKS(SUB_CLKS), .CW(CW)) u_sym (
        .code(cur_code), .half(half), .cnt(pre_cnt), .level(sym_level)
    );

    // Drive the line: high through sync, symbol pulses in the bit slots, low otherwise.
    always_comb begin
        tx_out = (phase == PH_SYNC) || ((phase == PH_BITS) && sym_level);
    end

    if (DATA_TRIGGER != 0) begin : g_ind
        assign tx_active = (phase != PH_IDLE);
        AST_LINE_NEEDS_INDICATOR: assert property (@(posedge clk) disable iff (!rst_n)
            tx_out |-> tx_active);  // R11
    end else begin : g_no_ind
        assign tx_active = 1'b0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> (!tx_out && !tx_active));  // R1
    AST_PILOT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PILOT) |-> !tx_out);  // R2
    AST_SYNC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SYNC) |-> tx_out);  // R2
    AST_SUBBIT_LEADS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_BITS) && (pre_cnt == '0)) |-> tx_out);  // R3
    AST_SUBBIT_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_BITS) && (pre_cnt == CNT_LAST)) |-> !tx_out);  // R3

endmodule

// File: tb/trinary_frame_encoder_tb_top.sv
// Bench: table-driven burst checks on a transmit-enable instance, then directed
// tests for reset, repeat, code capture and a data-trigger instance with masked slots.
module trinary_frame_encoder_tb_top;

    localparam int WORD_CLKS  = 1595;
    localparam int BURST_CLKS = 4785;
    localparam int NVEC       = 6;
    localparam logic [35:0] ALL_ONE = 36'hF_FFFF_FFFF;
    localparam logic [17:0] MASK_D  = 18'h0FFCF;

    localparam logic [35:0] VEC_CODE [NVEC] = '{
        36'h0_0000_0000, 36'hF_FFFF_FFFF, 36'h5_5555_5555,
        36'hA_AAAA_AAAA, 36'h3_3333_3333, 36'hF_FF55_5555
    };
    localparam int VEC_LONG [NVEC] = '{0, 36, 18, 18, 18, 24};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        te_i = 1'b0;
    logic        te_d = 1'b0;
    logic [35:0] code_i = '0;
    logic [35:0] code_d = '0;
    logic        tx_i, act_i, tx_d, act_d;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    trinary_frame_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .te(te_i), .pos_code(code_i),
        .tx_out(tx_i), .tx_active(act_i)
    );

    trinary_frame_encoder #(.DATA_TRIGGER(1), .USED_MASK(MASK_D)) dut_d_i (
        .clk(clk), .rst_n(rst_n), .te(te_d), .pos_code(code_d),
        .tx_out(tx_d), .tx_active(act_d)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected line level t clocks after the edge that starts a word run (R2 R3 R4).
    function automatic logic exp_level(input int t, input logic [35:0] c);
        int w, b, p, h, k;
        logic [1:0] cd;
        logic sv;
        w = t % WORD_CLKS;
        if (w < 396) return 1'b0;
        if (w < 407) return 1'b1;
        b = w - 407;
        p = b / 66;
        h = (b % 66) / 33;
        k = b % 33;
        cd = c[2*p +: 2];
        if (cd == 2'b00)      sv = 1'b0;
        else if (cd == 2'b11) sv = 1'b1;
        else                  sv = (h == 1);
        return (k < (sv ? 22 : 11));
    endfunction

    // Codes the data-trigger instance must send (R9 R10): slots 4,5,16,17 unused.
    function automatic logic [35:0] map_d(input logic [35:0] raw);
        logic [35:0] r;
        r = raw;
        for (int i = 0; i < 18; i++) begin
            if (i == 4 || i == 5)        r[2*i +: 2] = 2'b01;
            else if (i == 16 || i == 17) r[2*i +: 2] = 2'b00;
            else if (i >= 12)            r[2*i +: 2] = (raw[2*i +: 2] == 2'b11) ? 2'b11 : 2'b00;
        end
        return r;
    endfunction

    // Compare every clock of nwords words; called at the negedge after the start edge.
    task automatic watch_words(input bit sel, input logic [35:0] c0, input logic [35:0] cr,
                               input int nwords, input int exp_long, input int chg_t,
                               input logic [35:0] chg_v, input string req);
        for (int w = 0; w < nwords; w++) begin
            int bad = 0;
            int longs = 0;
            for (int t = 0; t < WORD_CLKS; t++) begin
                logic e, got, act;
                if (w * WORD_CLKS + t == chg_t) begin
                    if (sel) code_d = chg_v; else code_i = chg_v;
                end
                e   = exp_level(t, (w == 0) ? c0 : cr);
                got = sel ? tx_d : tx_i;
                act = sel ? act_d : act_i;
                if (got !== e || act !== sel) bad++;
                if (t >= 407 && ((t - 407) % 33) == 15 && got === 1'b1) longs++;
                @(negedge clk);
            end
            check(bad == 0, req, $sformatf("word %0d waveform mismatching clocks", w), bad, 0);
            if (exp_long >= 0)
                check(longs == exp_long, "R4", $sformatf("word %0d long sub-bits", w),
                      longs, exp_long);
        end
    endtask

    // Line and indicator must stay low for n clocks (R1 R5 R6 R9 R10 R11).
    task automatic idle_check(input bit sel, input int n, input string req);
        int bad = 0;
        for (int t = 0; t < n; t++) begin
            if ((sel ? tx_d : tx_i) !== 1'b0 || (sel ? act_d : act_i) !== 1'b0) bad++;
            @(negedge clk);
        end
        check(bad == 0, req, "idle clocks with activity", bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R5: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [35:0] raw1, raw_idle, raw2;
        // Reset state (R1)
        repeat (4) @(negedge clk);
        check(tx_i === 1'b0 && act_i === 1'b0, "R1", "outputs in reset", tx_i, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_i === 1'b0, "R1", "tx_out after reset", tx_i, 0);
        check(act_d === 1'b0, "R1", "tx_active after reset", act_d, 0);
        idle_check(0, 100, "R1");

        // Table of code patterns, each started by a one-clock te pulse (R2 R3 R4 R5 R8)
        for (int e = 0; e < NVEC; e++) begin
            code_i = VEC_CODE[e];
            te_i = 1'b1;
            @(negedge clk);
            te_i = 1'b0;
            watch_words(0, VEC_CODE[e], VEC_CODE[e], 3, VEC_LONG[e], -1, '0,
                        "R2 R3 R4 R5 R8");
            idle_check(0, 200, "R5");
        end

        // Code change in the middle of word 0 shows only from word 1 (R7)
        code_i = '0;
        te_i = 1'b1;
        @(negedge clk);
        te_i = 1'b0;
        watch_words(0, 36'h0, ALL_ONE, 3, -1, 600, ALL_ONE, "R7");
        idle_check(0, 200, "R7");

        // Enable held across the burst end gives a second burst, released then stops (R6)
        code_i = 36'h3_3333_3333;
        te_i = 1'b1;
        @(negedge clk);
        watch_words(0, code_i, code_i, 3, 18, -1, '0, "R5 R6");
        te_i = 1'b0;
        watch_words(0, code_i, code_i, 3, 18, -1, '0, "R6");
        idle_check(0, 300, "R6");

        // Data-trigger instance: codes per position
        raw1 = '0;
        raw1[1:0]   = 2'b11; raw1[3:2]   = 2'b00; raw1[5:4]   = 2'b01; raw1[7:6]   = 2'b10;
        raw1[9:8]   = 2'b11; raw1[11:10] = 2'b00; raw1[13:12] = 2'b11; raw1[15:14] = 2'b11;
        raw1[17:16] = 2'b00; raw1[19:18] = 2'b01; raw1[21:20] = 2'b11; raw1[23:22] = 2'b00;
        raw1[25:24] = 2'b01; raw1[27:26] = 2'b11; raw1[29:28] = 2'b00; raw1[31:30] = 2'b10;
        raw1[33:32] = 2'b11; raw1[35:34] = 2'b11;
        raw_idle = raw1; raw_idle[27:26] = 2'b01;
        raw2     = raw1; raw2[27:26]     = 2'b00;

        // te, open data codes and unused data slots must not start it (R9 R10 R11)
        code_d = raw_idle;
        te_d = 1'b1;
        @(negedge clk);
        idle_check(1, 300, "R9 R10 R11");
        te_d = 1'b0;

        // A used data position at one starts a full burst with masked slots (R9 R10 R11)
        code_d = raw1;
        @(negedge clk);
        code_d = raw2;
        watch_words(1, map_d(raw1), map_d(raw2), 3, -1, -1, '0, "R9 R10 R11");
        idle_check(1, 300, "R11");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule